// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is a byte-wide memory that a host reaches over a four-wire serial link in SPI mode 0. The host pulls chip select low, shifts in a one-byte command and a two-byte address, most significant bit first, and then moves data. A read command makes the slave return bytes on its serial output. A write command makes the slave store every complete byte it receives. In both cases the address steps forward after each byte and wraps from the last location back to zero, so a burst can run for as long as chip select stays low.

The storage is an internal register array of 2^ADDR_W bytes. Setting ADDR_W to 15 gives the full 32768 x 8 array. The default is a smaller 1024-byte array so that elaboration stays light. Address bits above ADDR_W-1 are don't-care, and that always includes bit 15.

The serial pins are sampled by the system clock `clk_i` through a SYNC_STAGES-deep synchronizer, and the SCK edges are detected in that clock domain. Each high phase and each low phase of SCK must last at least SYNC_STAGES+2 system clocks. Chip select must settle for the same time before the first SCK edge. Serial output comes with a separate enable, which an external pad uses as its tri-state control.

Top module: `spi_mem_slave`

## Requirements
- R1: A byte written to an address is returned by a later read of the same address. The array holds 2^ADDR_W bytes.
- R2: The first byte after chip select falls is the command, sampled on rising SCK edges, MSB first. 8'h03 means read and 8'h02 means write.
- R3: The command is followed by a 16-bit address, MSB first. Only bits ADDR_W-1:0 select a byte, and bit 15 (with every other bit at ADDR_W or above) has no effect.
- R4: During a read, the MSB of the first data byte is driven after the SCK falling edge that follows the 24th rising edge. The output then changes only after SCK falling edges, MSB first, one bit per SCK cycle.
- R5: During the data phase of a read, the serial input has no effect on the array.
- R6: `sdo_oe_o` is low, and `sdo_o` is low, whenever the slave is not driving read data. This includes idle time and the command and address phases.
- R7: During a write, a byte is stored when its eighth bit has been sampled. A byte cut short by chip select rising is discarded.
- R8: While chip select stays low, each further group of 8 SCK cycles reads or writes the next address.
- R9: After the highest location (2^ADDR_W - 1), the address wraps to 0 and the burst continues.
- R10: Chip select going high ends the command at any bit and disables the output. The next command is decoded from a fresh first byte.
- R11: A command byte other than 8'h03 or 8'h02 makes the slave ignore the rest of the transaction: nothing is written and the output stays disabled until chip select rises.
- R12: A high `rst_i` at a `clk_i` rising edge returns the slave to waiting for a command with the output disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; it oversamples the serial pins |
| rst_i | input | 1 | Synchronous reset, active high |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the host, idle low |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host, low when not enabled |
| sdo_oe_o | output | 1 | High while `sdo_o` carries read data |

## Verification
The bench writes the last two locations of the array and continues one byte past the top. It then reads back across the wrap. A slave that saturated, or that did not wrap, would return stale data at location 0. It writes through an address with bit 15 set and reads the same byte back through the address with bit 15 clear, which catches a decoder that uses the top bit. It also cuts a write byte off after five bits and sends a command byte that is neither read nor write. A slave that committed partial bytes or acted on unknown commands would corrupt a guarded location, and one that enabled its output too early, or left it enabled after chip select, a reset or a rejected command, shows up in the output-enable samples.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_FLD_W  = 16;

    localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;

    // Phase of the transaction currently on the wire
    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_READ,
        ST_WRITE,
        ST_IGNORE
    } mem_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_READ,
        CMD_WRITE
    } cmd_e;

    // Serial pin events as seen in the system clock domain
    typedef struct packed {
        logic cs_act;
        logic sck_rise;
        logic sck_fall;
        logic sdi;
    } spi_ev_t;

    function automatic cmd_e decode_op(input logic [BYTE_W-1:0] op);
        cmd_e c;
        case (op)
            OP_READ:  c = CMD_READ;
            OP_WRITE: c = CMD_WRITE;
            default:  c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync
    import spi_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    cs_n_i,
    input  logic    sck_i,
    input  logic    sdi_i,
    output spi_ev_t ev_o
);

    localparam int PIN_N = 3;
    localparam logic [PIN_N-1:0] PIN_IDLE = 3'b100; // cs_n high, sck low, sdi low

    logic [PIN_N-1:0] pins_raw;
    logic [PIN_N-1:0] chain_q [SYNC_STAGES];
    logic [PIN_N-1:0] pins_s;
    logic             sck_prev_q;
    logic             cs_act;

    assign pins_raw = {cs_n_i, sck_i, sdi_i};

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[0] <= PIN_IDLE;
                    else       chain_q[0] <= pins_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[g] <= PIN_IDLE;
                    else       chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign pins_s = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk_i) begin
        if (rst_i) sck_prev_q <= 1'b0;
        else       sck_prev_q <= pins_s[1];
    end

    assign cs_act = ~pins_s[2];

    always_comb begin
        ev_o.cs_act   = cs_act;
        ev_o.sck_rise = cs_act &  pins_s[1] & ~sck_prev_q;
        ev_o.sck_fall = cs_act & ~pins_s[1] &  sck_prev_q;
        ev_o.sdi      = pins_s[0];
    end

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) cells[addr_i] <= wdata_i;
    end

    assign rdata_o = cells[addr_i];

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  spi_ev_t           ev_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output mem_state_e        state_o
);

    localparam int          CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    mem_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bit_q;
    logic [BYTE_W-2:0] in_q;
    logic [BYTE_W-1:0] addr_hi_q;
    logic              addr_lo_next_q;
    logic              rd_cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] out_q;
    logic              oe_q;

    logic [BYTE_W-1:0] in_byte;
    logic              byte_end;
    logic              wr_commit;
    logic              rd_reload;

    assign in_byte   = {in_q, ev_i.sdi};
    assign byte_end  = ev_i.sck_rise && (bit_q == LAST_BIT);
    assign wr_commit = ev_i.cs_act && byte_end && (state_q == ST_WRITE);
    assign rd_reload = ev_i.sck_fall && (state_q == ST_READ) && (bit_q == '0);

    // Next phase of the transaction
    always_comb begin
        state_d = state_q;
        if (byte_end) begin
            case (state_q)
                ST_OPCODE: begin
                    if (decode_op(in_byte) == CMD_NONE) state_d = ST_IGNORE;
                    else                                state_d = ST_ADDR;
                end
                ST_ADDR: begin
                    if (addr_lo_next_q) state_d = rd_cmd_q ? ST_READ : ST_WRITE;
                end
                default: state_d = state_q;
            endcase
        end
        if (!ev_i.cs_act) state_d = ST_OPCODE;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q        <= ST_OPCODE;
            bit_q          <= '0;
            in_q           <= '0;
            addr_hi_q      <= '0;
            addr_lo_next_q <= 1'b0;
            rd_cmd_q       <= 1'b0;
            addr_q         <= '0;
            out_q          <= '0;
            oe_q           <= 1'b0;
        end else if (!ev_i.cs_act) begin
            state_q        <= ST_OPCODE;
            bit_q          <= '0;
            addr_lo_next_q <= 1'b0;
            oe_q           <= 1'b0;
        end else begin
            state_q <= state_d;

            if (ev_i.sck_rise) begin
                bit_q <= bit_q + CNT_ONE;
                in_q  <= in_byte[BYTE_W-2:0];
            end

            if (byte_end && state_q == ST_OPCODE)
                rd_cmd_q <= (decode_op(in_byte) == CMD_READ);

            if (byte_end && state_q == ST_ADDR) begin
                addr_lo_next_q <= ~addr_lo_next_q;
                if (!addr_lo_next_q) addr_hi_q <= in_byte;
                else                 addr_q    <= ADDR_W'({addr_hi_q, in_byte});
            end

            if (wr_commit) addr_q <= addr_q + 1'b1;

            if (ev_i.sck_fall && state_q == ST_READ) begin
                if (rd_reload) begin
                    out_q  <= mem_rdata_i;
                    addr_q <= addr_q + 1'b1;
                    oe_q   <= 1'b1;
                end else begin
                    out_q <= {out_q[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign mem_we_o    = wr_commit;
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = in_byte;
    assign sdo_o       = oe_q & out_q[BYTE_W-1];
    assign sdo_oe_o    = oe_q;
    assign state_o     = state_q;

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);

    spi_ev_t           ev;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_wdata;
    logic [BYTE_W-1:0] mem_rdata;
    mem_state_e        cur_state;
    logic              cs_act;
    logic              sck_fall_ev;

    spi_mem_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cs_n_i(cs_n_i),
        .sck_i (sck_i),
        .sdi_i (sdi_i),
        .ev_o  (ev)
    );

    spi_mem_ctrl #(
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ev_i       (ev),
        .mem_we_o   (mem_we),
        .mem_addr_o (mem_addr),
        .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o),
        .state_o    (cur_state)
    );

    spi_mem_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(BYTE_W)
    ) u_array (
        .clk_i  (clk_i),
        .we_i   (mem_we),
        .addr_i (mem_addr),
        .wdata_i(mem_wdata),
        .rdata_o(mem_rdata)
    );

    assign cs_act      = ev.cs_act;
    assign sck_fall_ev = ev.sck_fall;

endmodule

// File: rtl/spi_mem_chk.sv
module spi_mem_chk
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              sdo_o,
    input logic              sdo_oe_o,
    input mem_state_e        state,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cs_act,
    input logic              sck_fall
);

    AST_OE_ONLY_IN_READ: assert property (@(posedge clk_i) disable iff (rst_i)
        sdo_oe_o |-> (state == ST_READ)); // R6

    AST_CS_HIGH_IDLES: assert property (@(posedge clk_i) disable iff (rst_i)
        !cs_act |=> (state == ST_OPCODE && !sdo_oe_o)); // R10

    AST_SDO_MOVES_ON_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        (sdo_oe_o && $past(sdo_oe_o) && !$past(sck_fall)) |-> $stable(sdo_o)); // R4

    AST_WRITE_ADDR_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_we |=> (mem_addr == $past(mem_addr) + 1'b1)); // R9

    AST_NO_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_IGNORE) |-> !mem_we); // R11

endmodule

bind spi_mem_slave spi_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .sdo_o   (sdo_o),
    .sdo_oe_o(sdo_oe_o),
    .state   (cur_state),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .cs_act  (cs_act),
    .sck_fall(sck_fall_ev)
);

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;
    localparam int DEPTH      = 1 << AW;
    localparam int MASK       = DEPTH - 1;
    localparam int HALF       = 5;      // system clocks per SCK phase
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_i, cs_n_i, sck_i, sdi_i;
    logic sdo_o, sdo_oe_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_mem_slave #(.ADDR_W(AW), .SYNC_STAGES(2)) dut (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .cs_n_i  (cs_n_i),
        .sck_i   (sck_i),
        .sdi_i   (sdi_i),
        .sdo_o   (sdo_o),
        .sdo_oe_o(sdo_oe_o)
    );

    int           n_vec  = 0;
    int           n_miss = 0;
    bit           done   = 0;
    logic [7:0]   model [int];
    logic [7:0]   exp_q [$];
    bit           rd_phase = 0;
    bit           hdr_phase = 0;
    bit           hdr_oe_seen = 0;
    int           mon_cnt = 0;
    logic [7:0]   mon_sh = '0;
    bit           mon_oe_ok = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: host-side sampling on rising SCK, scoreboard compare per byte
    always @(posedge sck_i) begin
        if (hdr_phase && sdo_oe_o) hdr_oe_seen = 1;
        if (rd_phase) begin
            mon_sh    = {mon_sh[6:0], sdo_o};
            mon_oe_ok = mon_oe_ok & sdo_oe_o;
            mon_cnt++;
            if (mon_cnt == 8) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected read byte", mon_sh, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(mon_oe_ok && mon_sh == e, "R1 R4 R8 read byte", {mon_oe_ok, mon_sh}, {1'b1, e});
                end
                mon_cnt   = 0;
                mon_oe_ok = 1;
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sdi_i <= tx[7-i];
            wait_clk(HALF);
            sck_i <= 1'b1;
            wait_clk(HALF);
            sck_i <= 1'b0;
        end
    endtask

    task automatic cs_lo();
        cs_n_i <= 1'b0;
        mon_cnt   = 0;
        mon_oe_ok = 1;
        wait_clk(6);
    endtask

    task automatic cs_hi();
        wait_clk(3);
        cs_n_i <= 1'b1;
        wait_clk(8);
    endtask

    task automatic header(input logic [7:0] op, input logic [15:0] a);
        hdr_phase   = 1;
        hdr_oe_seen = 0;
        spi_bits(op, 8);
        spi_bits(a[15:8], 8);
        spi_bits(a[7:0], 8);
        hdr_phase = 0;
        chk(!hdr_oe_seen, "R6 output off in op/addr", hdr_oe_seen, 0);
    endtask

    task automatic wr_burst(input logic [15:0] a, input logic [7:0] d [$]);
        cs_lo();
        header(8'h02, a);
        foreach (d[i]) begin
            spi_bits(d[i], 8);
            model[(int'(a) + i) & MASK] = d[i];
        end
        cs_hi();
    endtask

    task automatic rd_burst(input logic [15:0] a, input int n, input logic [7:0] sdi_pat);
        for (int i = 0; i < n; i++) exp_q.push_back(model[(int'(a) + i) & MASK]);
        cs_lo();
        header(8'h03, a);
        rd_phase = 1;
        for (int i = 0; i < n; i++) spi_bits(sdi_pat, 8);
        rd_phase = 0;
        cs_hi();
        chk(exp_q.size() == 0, "R4 all read bytes seen", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_miss++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        rst_i  = 1'b1;
        cs_n_i = 1'b1;
        sck_i  = 1'b0;
        sdi_i  = 1'b0;
        wait_clk(5);
        // R12 reset state
        chk(sdo_oe_o == 1'b0 && sdo_o == 1'b0, "R12 R6 reset state", {sdo_oe_o, sdo_o}, 0);
        rst_i = 1'b0;
        wait_clk(5);

        // R1 R2 R7: single write then read
        wr_burst(16'h0010, '{8'h5A});
        rd_burst(16'h0010, 1, 8'h00);

        // R8: burst write and burst read
        wr_burst(16'h0100, '{8'h11, 8'h82, 8'hC7, 8'h3E});
        rd_burst(16'h0100, 4, 8'h00);

        // R9: write wraps from top to 0, read wraps too
        wr_burst(16'(MASK - 1), '{8'hA1, 8'hB2, 8'hC3});
        rd_burst(16'(MASK), 2, 8'h00);
        rd_burst(16'h0000, 1, 8'h00);

        // R3: address bit 15 is ignored
        wr_burst(16'h8020, '{8'h96});
        model[16'h0020] = 8'h96;
        rd_burst(16'h0020, 1, 8'h00);
        rd_burst(16'h8020, 1, 8'h00);

        // R5: sdi toggling during read data does not alter contents
        rd_burst(16'h0100, 2, 8'hFF);
        rd_burst(16'h0100, 2, 8'h00);

        // R7: partial byte discarded
        wr_burst(16'h0041, '{8'hA5});
        cs_lo();
        header(8'h02, 16'h0040);
        spi_bits(8'h11, 8);
        model[16'h0040] = 8'h11;
        spi_bits(8'h00, 5);
        cs_hi();
        rd_burst(16'h0040, 2, 8'h00);

        // R11: unknown command ignored
        cs_lo();
        hdr_phase   = 1;
        hdr_oe_seen = 0;
        spi_bits(8'h06, 8);
        spi_bits(8'h00, 8);
        spi_bits(8'h41, 8);
        spi_bits(8'h77, 8);
        spi_bits(8'h55, 8);
        hdr_phase = 0;
        chk(!hdr_oe_seen, "R11 output off after bad command", hdr_oe_seen, 0);
        cs_hi();
        rd_burst(16'h0041, 1, 8'h00);

        // R10: chip select rises inside the address, next command still works
        cs_lo();
        spi_bits(8'h03, 8);
        spi_bits(8'h00, 8);
        spi_bits(8'h00, 3);
        cs_hi();
        chk(sdo_oe_o == 1'b0, "R10 output off after abort", sdo_oe_o, 0);
        wr_burst(16'h0050, '{8'h3C});
        rd_burst(16'h0050, 1, 8'h00);

        // R10 R6: chip select rises inside read data
        cs_lo();
        header(8'h03, 16'h0100);
        spi_bits(8'h00, 4);
        chk(sdo_oe_o == 1'b1, "R4 output on during read data", sdo_oe_o, 1);
        cs_hi();
        chk(sdo_oe_o == 1'b0 && sdo_o == 1'b0, "R10 R6 output off after cs high", {sdo_oe_o, sdo_o}, 0);

        // R12: reset in the middle of a read
        cs_lo();
        header(8'h03, 16'h0010);
        spi_bits(8'h00, 3);
        chk(sdo_oe_o == 1'b1, "R4 output on before reset", sdo_oe_o, 1);
        rst_i = 1'b1;
        wait_clk(2);
        chk(sdo_oe_o == 1'b0 && sdo_o == 1'b0, "R12 reset mid read", {sdo_oe_o, sdo_o}, 0);
        rst_i = 1'b0;
        cs_hi();
        rd_burst(16'h0010, 1, 8'h00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule